// File: doc/BRIEF.md
# Interrupt Configuration Byte Cache

This block keeps a local copy of the per-interrupt configuration bytes for message-signalled interrupts whose IDs start at 8192. Each byte carries a 6-bit priority and an enable flag. A priority scanner reads these through lookup ports and gets an answer in the same cycle. The copies live in flops. Memory is read only when software asks for a refresh, either for one ID or for every implemented ID in one sweep.

Software programs a properties register that holds the table's base address and an ID-width field. The ID-width field sets the largest implemented ID as 2^(field+1), and the cache depth parameter caps the number of entries. A refresh issues one byte read per entry on a simple request/response memory port. While a refresh runs, the busy output is high, and writes that could change the refresh in progress are held off.

Top module: `lpi_cfg_cache`

## Requirements
- R1: After reset, offset 0x70 reads 0. A write to 0x70 keeps data bits [51:12] as the table base and bits [4:0] as the ID-width field. A read of 0x70 returns the base OR the ID-width field, with every other bit 0.
- R2: An ID-width value above 15 is stored as 15.
- R3: The implemented count is min(2^(W+1) − 8192 + 1, SLOTS) when 2^(W+1) ≥ 8192, and 0 otherwise, where W is the stored ID-width field. The entry index of an ID is the ID minus 8192.
- R4: A write of an ID in data[31:0] to offset 0xA0 issues exactly one memory read at base + index. The returned byte replaces that entry.
- R5: A write to 0xA0 is ignored when the ID is below 8192 or its index is not below the implemented count. An ignored write issues no memory read and does not raise busy.
- R6: Any write to 0xB0 reads every implemented entry, at base + 0, base + 1, and so on in ascending order. When the implemented count is 0, it issues no read.
- R7: Offset 0xC0 always reads 0.
- R8: A lookup returns priority = entry bits [7:2] and enable = entry bit 0. Bit 1 is ignored. An ID below 8192 or at or beyond the implemented count returns priority 0 and enable 0. After reset, all entries are 0.
- R9: A change in memory has no effect on a cached entry until that entry is refetched.
- R10: Busy rises the cycle after a refresh is accepted and falls after the last response is stored. While busy is high, regWrReady is low for offsets 0x70, 0xA0 and 0xB0, and a write to those offsets is not taken. For any other offset, regWrReady is high.
- R11: A memory request stays valid with a stable address until memReqReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write request |
| regAddr | input | 8 | Register offset for both read and write |
| regWrData | input | 64 | Register write data |
| regWrReady | output | 1 | Write is taken in a cycle where regWrEn and this are both high |
| regRdData | output | 64 | Read data for regAddr, combinational |
| busy | output | 1 | Refresh in progress |
| memReqValid | output | 1 | Memory byte read request |
| memReqAddr | output | 52 | Byte address of the request |
| memReqReady | input | 1 | Memory accepts the request |
| memRspValid | input | 1 | Response byte valid |
| memRspData | input | 8 | Response byte |
| lookupId | input | 32*NUM_LOOKUP | IDs queried by the scanner, one 32-bit lane each |
| lookupPrio | output | 6*NUM_LOOKUP | Priority per lane |
| lookupEnable | output | NUM_LOOKUP | Enable per lane |

## Verification
The assertions check several properties on every cycle:
- the memory request holds steady under back-pressure;
- no request appears while busy is low;
- held-off writes and ready track the busy state;
- the properties read-back never shows bits outside its two fields or an ID width above 15;
- lanes queried with IDs below 8192 stay disabled.

Other behaviour needs the directed scenarios:
- which address each refresh fetches, and the ascending order of a sweep;
- the boundary of the implemented count;
- the fact that cached bytes go stale until they are invalidated.

// File: rtl/lpicfg_pkg.sv
package lpicfg_pkg;
  localparam int unsigned FIRST_LPI = 8192;
  localparam int unsigned ID_BITS_CEIL = 15;

  localparam logic [7:0] OFS_PROPS   = 8'h70;
  localparam logic [7:0] OFS_INV_ONE = 8'hA0;
  localparam logic [7:0] OFS_INV_ALL = 8'hB0;
  localparam logic [7:0] OFS_SYNC    = 8'hC0;

  // strobes from control to datapath
  typedef struct packed {
    logic        baseWr;
    logic        entryWr;
    logic [15:0] fetchIdx;
  } cfgStrobes_t;

  // cached form: priority in [6:1], enable in [0]; reserved bit dropped
  function automatic logic [6:0] packEntry(input logic [7:0] raw);
    return {raw[7:2], raw[0]};
  endfunction
endpackage

// File: rtl/lpicfg_datapath.sv
module lpicfg_datapath
  import lpicfg_pkg::*;
#(
  parameter int SLOTS      = 64,
  parameter int NUM_LOOKUP = 2,
  parameter int ADDR_W     = 52
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cfgStrobes_t              strobes,
  input  logic [7:0]               regAddr,
  input  logic [63:0]              regWrData,
  input  logic [7:0]               memRspData,
  input  logic [32*NUM_LOOKUP-1:0] lookupId,
  output logic [63:0]              regRdData,
  output logic [ADDR_W-1:0]        memReqAddr,
  output logic [16:0]              liveCount,
  output logic [6*NUM_LOOKUP-1:0]  lookupPrio,
  output logic [NUM_LOOKUP-1:0]    lookupEnable
);
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [ADDR_W-1:0] ADDR_MASK = {{(ADDR_W-12){1'b1}}, 12'h000};

  logic [ADDR_W-1:0] propsAddr;
  logic [4:0]        idBits;
  logic [16:0]       largestId;
  logic [16:0]       rawCount;
  logic [6:0]        slotQ [SLOTS];

  // properties register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      propsAddr <= '0;
      idBits    <= '0;
    end else if (strobes.baseWr) begin
      propsAddr <= regWrData[ADDR_W-1:0] & ADDR_MASK;
      idBits    <= (regWrData[4:0] > 5'(ID_BITS_CEIL)) ? 5'(ID_BITS_CEIL) : regWrData[4:0];
    end
  end

  // implemented range
  always_comb begin
    largestId = 17'd1 << (idBits + 5'd1);
    if (largestId >= 17'(FIRST_LPI))
      rawCount = largestId - 17'(FIRST_LPI) + 17'd1;
    else
      rawCount = '0;
    liveCount = (rawCount > 17'(SLOTS)) ? 17'(SLOTS) : rawCount;
  end

  // entry storage
  always_ff @(posedge clk) begin
    for (int i = 0; i < SLOTS; i++) begin
      if (!rstN)
        slotQ[i] <= '0;
      else if (strobes.entryWr && strobes.fetchIdx == 16'(i))
        slotQ[i] <= packEntry(memRspData);
    end
  end

  assign memReqAddr = propsAddr + ADDR_W'(strobes.fetchIdx);

  always_comb begin
    regRdData = '0;
    case (regAddr)
      OFS_PROPS: regRdData = 64'(propsAddr) | 64'(idBits);
      OFS_SYNC:  regRdData = '0;
      default:   regRdData = '0;
    endcase
  end

  // lookup lanes
  for (genvar k = 0; k < NUM_LOOKUP; k++) begin : g_lane
    logic [31:0] qid;
    logic [31:0] rel;
    logic        hit;
    logic [6:0]  entry;
    assign qid   = lookupId[32*k +: 32];
    assign rel   = qid - 32'(FIRST_LPI);
    assign hit   = (qid >= 32'(FIRST_LPI)) && (rel < 32'(liveCount));
    assign entry = slotQ[rel[IDX_W-1:0]];
    assign lookupPrio[6*k +: 6] = hit ? entry[6:1] : 6'd0;
    assign lookupEnable[k]      = hit & entry[0];
  end
endmodule

// File: rtl/lpicfg_control.sv
module lpicfg_control
  import lpicfg_pkg::*;
#(
  parameter int SLOTS = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [7:0]  regAddr,
  input  logic [31:0] reqId,
  input  logic [16:0] liveCount,
  input  logic        memReqReady,
  input  logic        memRspValid,
  output logic        regWrReady,
  output logic        busy,
  output logic        memReqValid,
  output cfgStrobes_t strobes
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_AWAIT} ctlState_t;

  ctlState_t   state;
  logic [15:0] fetchIdx;
  logic [15:0] lastIdx;
  logic        guarded;
  logic        accept;
  logic [31:0] reqRel;
  logic        oneValid;

  assign busy        = (state != ST_IDLE);
  assign guarded     = (regAddr == OFS_PROPS) || (regAddr == OFS_INV_ONE) || (regAddr == OFS_INV_ALL);
  assign regWrReady  = !(busy && guarded);
  assign accept      = regWrEn && regWrReady;
  assign reqRel      = reqId - 32'(FIRST_LPI);
  assign oneValid    = (reqId >= 32'(FIRST_LPI)) && (reqRel < 32'(liveCount));
  assign memReqValid = (state == ST_ISSUE);

  always_comb begin
    strobes.baseWr   = accept && (regAddr == OFS_PROPS);
    strobes.entryWr  = (state == ST_AWAIT) && memRspValid;
    strobes.fetchIdx = fetchIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      fetchIdx <= '0;
      lastIdx  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept && regAddr == OFS_INV_ONE && oneValid) begin
            fetchIdx <= reqRel[15:0];
            lastIdx  <= reqRel[15:0];
            state    <= ST_ISSUE;
          end else if (accept && regAddr == OFS_INV_ALL && liveCount != 17'd0) begin
            fetchIdx <= '0;
            lastIdx  <= 16'(liveCount - 17'd1);
            state    <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (memReqReady) state <= ST_AWAIT;
        end
        ST_AWAIT: begin
          if (memRspValid) begin
            if (fetchIdx == lastIdx) begin
              state <= ST_IDLE;
            end else begin
              fetchIdx <= fetchIdx + 16'd1;
              state    <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lpi_cfg_cache.sv
module lpi_cfg_cache
  import lpicfg_pkg::*;
#(
  parameter int SLOTS      = 64,
  parameter int NUM_LOOKUP = 2,
  parameter int ADDR_W     = 52
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWrEn,
  input  logic [7:0]               regAddr,
  input  logic [63:0]              regWrData,
  output logic                     regWrReady,
  output logic [63:0]              regRdData,
  output logic                     busy,
  output logic                     memReqValid,
  output logic [ADDR_W-1:0]        memReqAddr,
  input  logic                     memReqReady,
  input  logic                     memRspValid,
  input  logic [7:0]               memRspData,
  input  logic [32*NUM_LOOKUP-1:0] lookupId,
  output logic [6*NUM_LOOKUP-1:0]  lookupPrio,
  output logic [NUM_LOOKUP-1:0]    lookupEnable
);
  cfgStrobes_t strobes;
  logic [16:0] liveCount;

  lpicfg_control #(.SLOTS(SLOTS)) u_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .reqId(regWrData[31:0]), .liveCount(liveCount),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .regWrReady(regWrReady), .busy(busy), .memReqValid(memReqValid),
    .strobes(strobes)
  );

  lpicfg_datapath #(.SLOTS(SLOTS), .NUM_LOOKUP(NUM_LOOKUP), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regAddr(regAddr),
    .regWrData(regWrData), .memRspData(memRspData), .lookupId(lookupId),
    .regRdData(regRdData), .memReqAddr(memReqAddr), .liveCount(liveCount),
    .lookupPrio(lookupPrio), .lookupEnable(lookupEnable)
  );
endmodule

// File: rtl/lpicfg_checker.sv
module lpicfg_checker
  import lpicfg_pkg::*;
#(
  parameter int NUM_LOOKUP = 2,
  parameter int ADDR_W     = 52
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     regWrEn,
  input logic [7:0]               regAddr,
  input logic                     regWrReady,
  input logic [63:0]              regRdData,
  input logic                     busy,
  input logic                     memReqValid,
  input logic [ADDR_W-1:0]        memReqAddr,
  input logic                     memReqReady,
  input logic [32*NUM_LOOKUP-1:0] lookupId,
  input logic [NUM_LOOKUP-1:0]    lookupEnable
);
  localparam logic [63:0] PROPS_KEEP = 64'(({{(ADDR_W-12){1'b1}}, 12'h000})) | 64'h1F;

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  assert_req_only_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> busy);

  assert_stall_guarded_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy && regWrEn && (regAddr == OFS_PROPS || regAddr == OFS_INV_ONE || regAddr == OFS_INV_ALL)
      |-> !regWrReady);

  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> regWrReady);

  assert_props_fields_R1: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == OFS_PROPS |-> (regRdData & ~PROPS_KEEP) == 64'd0);

  assert_idbits_clamp_R2: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == OFS_PROPS |-> regRdData[4:0] <= 5'(ID_BITS_CEIL));

  assert_sync_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == OFS_SYNC |-> regRdData == 64'd0);

  for (genvar k = 0; k < NUM_LOOKUP; k++) begin : g_lanechk
    assert_low_id_off_R8: assert property (@(posedge clk) disable iff (!rstN)
      lookupId[32*k +: 32] < 32'(FIRST_LPI) |-> !lookupEnable[k]);
  end
endmodule

bind lpi_cfg_cache lpicfg_checker #(.NUM_LOOKUP(NUM_LOOKUP), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrReady(regWrReady), .regRdData(regRdData), .busy(busy),
  .memReqValid(memReqValid), .memReqAddr(memReqAddr), .memReqReady(memReqReady),
  .lookupId(lookupId), .lookupEnable(lookupEnable)
);

// File: tb/sim_lpi_cfg_cache.sv
`timescale 1ns/1ps
module sim_lpi_cfg_cache;
  localparam int SLOTS = 64;
  localparam int NL    = 2;
  localparam int AW    = 52;
  localparam int FIRST = 8192;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            regWrEn = 1'b0;
  logic [7:0]      regAddr = 8'h00;
  logic [63:0]     regWrData = '0;
  logic            regWrReady;
  logic [63:0]     regRdData;
  logic            busy;
  logic            memReqValid;
  logic [AW-1:0]   memReqAddr;
  logic            memReqReady = 1'b1;
  logic            memRspValid = 1'b0;
  logic [7:0]      memRspData = '0;
  logic [32*NL-1:0] lookupId = '0;
  logic [6*NL-1:0] lookupPrio;
  logic [NL-1:0]   lookupEnable;

  int unsigned checks = 0;
  int unsigned fails = 0;
  int unsigned reqCount = 0;
  logic [AW-1:0] reqLog [128];
  logic [7:0] memSalt = 8'h00;
  bit done = 0;

  always #10 clk = ~clk;

  lpi_cfg_cache #(.SLOTS(SLOTS), .NUM_LOOKUP(NL), .ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regWrReady(regWrReady), .regRdData(regRdData),
    .busy(busy), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .memRspData(memRspData),
    .lookupId(lookupId), .lookupPrio(lookupPrio), .lookupEnable(lookupEnable)
  );

  function automatic logic [7:0] memByte(input logic [AW-1:0] a);
    return (a[7:0] * 8'd29 + 8'd7) ^ memSalt;
  endfunction

  // memory model: one-cycle response
  always @(posedge clk) begin
    memRspValid <= memReqValid && memReqReady;
    memRspData  <= memByte(memReqAddr);
    if (memReqValid && memReqReady) begin
      if (reqCount < 128) reqLog[reqCount] <= memReqAddr;
      reqCount <= reqCount + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    while (!regWrReady) @(negedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic look(input int lane, input int id, output logic [5:0] p, output logic e);
    @(negedge clk);
    lookupId[32*lane +: 32] = 32'(id);
    #1;
    p = lookupPrio[6*lane +: 6];
    e = lookupEnable[lane];
  endtask

  task automatic expectEntry(input string req, input int lane, input int id,
                             input logic [AW-1:0] base);
    logic [5:0] p; logic e; logic [7:0] b;
    b = memByte(base + AW'(id - FIRST));
    look(lane, id, p, e);
    chk(p == b[7:2], req, $sformatf("prio id %0d", id), 64'(p), 64'(b[7:2]));
    chk(e == b[0],   req, $sformatf("enable id %0d", id), 64'(e), 64'(b[0]));
  endtask

  task automatic expectOff(input string req, input int lane, input int id);
    logic [5:0] p; logic e;
    look(lane, id, p, e);
    chk(p == 6'd0 && e == 1'b0, req, $sformatf("disabled id %0d", id), {p, e}, 64'd0);
  endtask

  localparam logic [AW-1:0] BASE_A = 52'h0_0012_3450_0000;

  task automatic t_reset();
    logic [63:0] d;
    regRead(8'h70, d);
    chk(d == 64'd0, "R1", "props after reset", d, 64'd0);
    chk(busy == 1'b0 && regWrReady == 1'b1, "R10", "idle after reset", {busy, regWrReady}, 64'b01);
    expectOff("R8", 0, FIRST);
    regRead(8'hC0, d);
    chk(d == 64'd0, "R7", "sync reads zero", d, 64'd0);
  endtask

  task automatic t_props();
    logic [63:0] d;
    regWrite(8'h70, 64'hFFFF_FFFF_FFFF_FFFF);
    regRead(8'h70, d);
    chk(d == 64'h000F_FFFF_FFFF_F00F, "R2", "clamped props", d, 64'h000F_FFFF_FFFF_F00F);
    regWrite(8'h70, 64'hABC0_0000_0000_0FEE);
    regRead(8'h70, d);
    chk(d == 64'h0000_0000_0000_000E, "R1", "masked props", d, 64'h0000_0000_0000_000E);
    regWrite(8'h70, 64'(BASE_A) | 64'd13);
    regRead(8'h70, d);
    chk(d == (64'(BASE_A) | 64'd13), "R1", "base readback", d, 64'(BASE_A) | 64'd13);
  endtask

  task automatic t_single();
    int n0;
    memSalt = 8'h00;
    n0 = reqCount;
    regWrite(8'hA0, 64'(FIRST + 6));
    chk(busy == 1'b1, "R10", "busy after invalidate", 64'(busy), 64'd1);
    waitIdle();
    chk(reqCount == n0 + 1, "R4", "one request", 64'(reqCount - n0), 64'd1);
    chk(reqLog[n0] == BASE_A + 6, "R4", "request address", 64'(reqLog[n0]), 64'(BASE_A + 6));
    expectEntry("R4", 0, FIRST + 6, BASE_A);
    expectEntry("R8", 1, FIRST + 6, BASE_A);
    expectOff("R8", 0, FIRST + 7);
  endtask

  task automatic t_ignored();
    int n0;
    n0 = reqCount;
    regWrite(8'hA0, 64'(FIRST - 1));
    chk(busy == 1'b0, "R5", "no busy for low id", 64'(busy), 64'd0);
    regWrite(8'hA0, 64'(FIRST + SLOTS));
    repeat (4) @(negedge clk);
    chk(reqCount == n0, "R5", "no request when out of range", 64'(reqCount - n0), 64'd0);
    regWrite(8'h70, 64'(BASE_A) | 64'd12);
    regWrite(8'hA0, 64'(FIRST + 1));
    repeat (4) @(negedge clk);
    chk(reqCount == n0, "R3", "index 1 beyond count 1", 64'(reqCount - n0), 64'd0);
    expectOff("R3", 0, FIRST + 6);
    regWrite(8'hA0, 64'(FIRST));
    waitIdle();
    chk(reqCount == n0 + 1, "R3", "largest id accepted", 64'(reqCount - n0), 64'd1);
    expectEntry("R3", 0, FIRST, BASE_A);
  endtask

  task automatic t_stale();
    logic [7:0] oldB;
    oldB = memByte(BASE_A);
    memSalt = 8'hA5;
    expectOff("R9", 1, FIRST - 5);
    begin
      logic [5:0] p; logic e;
      look(0, FIRST, p, e);
      chk(p == oldB[7:2] && e == oldB[0], "R9", "stale entry kept", {p, e}, {oldB[7:2], oldB[0]});
    end
    regWrite(8'hA0, 64'(FIRST));
    waitIdle();
    expectEntry("R9", 0, FIRST, BASE_A);
  endtask

  task automatic t_sweep();
    int n0; bit ordered;
    memSalt = 8'h3C;
    regWrite(8'h70, 64'(BASE_A) | 64'd13);
    n0 = reqCount;
    regWrite(8'hB0, 64'd0);
    waitIdle();
    chk(reqCount == n0 + SLOTS, "R6", "sweep request count", 64'(reqCount - n0), 64'(SLOTS));
    ordered = 1;
    for (int i = 0; i < SLOTS; i++)
      if (reqLog[n0 + i] != BASE_A + AW'(i)) ordered = 0;
    chk(ordered, "R6", "ascending sweep addresses", 64'(ordered), 64'd1);
    expectEntry("R6", 0, FIRST, BASE_A);
    expectEntry("R6", 1, FIRST + 33, BASE_A);
    expectEntry("R6", 0, FIRST + SLOTS - 1, BASE_A);
    expectOff("R8", 1, FIRST + SLOTS);
    expectOff("R8", 0, 100);
  endtask

  task automatic t_sweepEmpty();
    int n0;
    regWrite(8'h70, 64'(BASE_A) | 64'd11);
    n0 = reqCount;
    regWrite(8'hB0, 64'd0);
    repeat (4) @(negedge clk);
    chk(reqCount == n0 && busy == 1'b0, "R6", "empty sweep", 64'(reqCount - n0), 64'd0);
    expectOff("R3", 0, FIRST);
  endtask

  task automatic t_stall();
    logic [63:0] d; logic [AW-1:0] held; bit steady;
    regWrite(8'h70, 64'(BASE_A) | 64'd13);
    @(negedge clk);
    memReqReady = 1'b0;
    regWrite(8'hA0, 64'(FIRST + 9));
    held = memReqAddr;
    steady = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!memReqValid || memReqAddr != held) steady = 0;
    end
    chk(steady, "R11", "request held under back-pressure", 64'(steady), 64'd1);
    chk(held == BASE_A + 9, "R11", "held address", 64'(held), 64'(BASE_A + 9));
    regAddr = 8'h70; regWrData = 64'd5; regWrEn = 1'b1;
    #1 chk(regWrReady == 1'b0, "R10", "props write held off", 64'(regWrReady), 64'd0);
    @(negedge clk);
    regAddr = 8'hC0;
    #1 chk(regWrReady == 1'b1, "R10", "other offset ready", 64'(regWrReady), 64'd1);
    regWrEn = 1'b0;
    memReqReady = 1'b1;
    waitIdle();
    regRead(8'h70, d);
    chk(d == (64'(BASE_A) | 64'd13), "R10", "props unchanged by held write", d, 64'(BASE_A) | 64'd13);
    expectEntry("R4", 1, FIRST + 9, BASE_A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_props();
    t_single();
    t_ignored();
    t_stale();
    t_sweep();
    t_sweepEmpty();
    t_stall();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule